// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends characters on an asynchronous serial line. A one-entry holding register sits in front of a frame shifter, so software can queue the next character while the current one is still going out. Characters carry 5, 6, 7, 8 or 9 data bits. Parity can be added, and each frame ends with one or two stop bits. A bit lasts a fixed number of baud ticks, which come from an external rate generator.

Software drives two write ports. The command port holds the transmit enable, the high bit of the character-size code and the staged ninth data bit. The format port holds the line mode, the parity code, the stop-bit select and the two low character-size bits. A separate data port writes the low eight data bits. That write latches them together with the staged ninth bit into the holding register. Once enabled in asynchronous mode, the block drives a pin-claim output. When the enable is cleared, the block keeps the pin until every queued character has been sent.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high, the pin-claim output is low, the buffer-empty flag is high and the transmit-complete flag is low.
- R2: When the enable is set and the line mode is 00, the pin-claim output rises one clock after the configuration write takes effect. No frame starts while the pin is not claimed.
- R3: Line-mode codes 01 (synchronous), 10 (reserved) and 11 (master SPI) keep the transmitter from claiming the pin or sending. A character written meanwhile stays in the holding register and the line stays high.
- R4: A frame is sent in this order: one low start bit, then the data bits LSB first, then the parity bit if parity is enabled, then high stop bits. The line is high whenever the pin is not claimed.
- R5: The character-size code is {command high bit, format low bits}. Code 000 gives 5 data bits, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. The codes 100, 101 and 110 give 8.
- R6: Parity code 10 appends even parity of the data bits and 11 appends odd parity. Codes 00 and 01 send no parity bit.
- R7: Stop select 0 sends one stop bit and 1 sends two. The frame length shows in when transmit-complete rises.
- R8: The ninth data bit is taken from the staged command bit at the moment the data write is accepted. Later changes to the staged bit do not alter a character already accepted.
- R9: A data write is accepted only when buffer-empty is high, and acceptance clears buffer-empty. Buffer-empty rises again when the character moves into the shifter. A data write while the buffer is full is dropped.
- R10: A character waiting in the buffer starts its start bit on the clock right after the previous frame's last stop bit ends, with no idle bit time.
- R11: Transmit-complete rises when a last stop bit ends and no character is waiting. An accepted data write clears it.
- R12: Clearing the enable, or leaving mode 00, keeps the pin claimed until the shifter and the buffer are both empty. The pin is released one clock after the final stop bit ends.
- R13: Each bit lasts 16 baud ticks, not 16 clocks. With a tick every other clock, a bit takes 32 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One pulse per oversampling tick |
| data_we | input | 1 | Data write strobe |
| data_in | input | 8 | Low eight data bits |
| cmd_we | input | 1 | Command write strobe |
| cmd_tx_en | input | 1 | Transmit enable |
| cmd_size_hi | input | 1 | High bit of character-size code |
| cmd_bit8 | input | 1 | Staged ninth data bit |
| fmt_we | input | 1 | Format write strobe |
| fmt_mode | input | 2 | Line mode, 00 is asynchronous |
| fmt_parity | input | 2 | Parity code |
| fmt_stop2 | input | 1 | Two stop bits when high |
| fmt_size_lo | input | 2 | Low bits of character-size code |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | Pin claimed by the transmitter |
| buf_empty | output | 1 | Holding register can take a character |
| tx_done | output | 1 | Transmit complete |

## Verification
On every cycle, the assertions check that the line sits high while the pin is unclaimed and that a start bit only falls while the pin is claimed. They also check that the pin is only claimed after an asynchronous enable, that it is only released with both stages drained, that transmit-complete only rises with an empty buffer and an idle line, and that an accepted write fills the buffer and clears transmit-complete. The bit-level frame content for each size, parity and stop combination can only be shown by the bench's scenarios. The same holds for the gapless hand-over, the ninth-bit latching and the tick-based bit timing, all of which the bench checks by sampling each bit at its midpoint.

// File: rtl/sertx_pkg.sv
// Shared types and frame helpers for the serial transmitter.
// Assumes at most nine data bits, one parity bit and two stop bits.
package sertx_pkg;

    localparam int DATA_MAX = 9;
    localparam int FRAME_W  = 1 + DATA_MAX + 1 + 2;
    localparam int LEN_W    = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'b00,
        MODE_SYNC  = 2'b01,
        MODE_RSVD  = 2'b10,
        MODE_SPI   = 2'b11
    } line_mode_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } frame_cfg_t;

    // Build the frame vector, LSB first on the wire; unused upper bits stay high
    function automatic logic [FRAME_W-1:0] frame_build(input logic [DATA_MAX-1:0] d,
                                                        input frame_cfg_t c);
        logic [FRAME_W-1:0] f;
        logic               p;
        f    = '1;
        f[0] = 1'b0;
        p    = c.par_odd;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < int'(c.nbits)) begin
                f[i+1] = d[i];
                p      = p ^ d[i];
            end
        end
        if (c.par_en) f[int'(c.nbits) + 1] = p;
        return f;
    endfunction

    // Index of the final bit of a frame (frame length minus one)
    function automatic logic [LEN_W-1:0] frame_last(input frame_cfg_t c);
        return LEN_W'(c.nbits) + LEN_W'(c.par_en) + LEN_W'(1) + LEN_W'(c.stop2);
    endfunction

endpackage

// File: rtl/sertx_cfg.sv
// Configuration registers and decode.
// Holds the command and format fields, decodes the character size and
// parity, and reports whether transmission is allowed (enable with mode 00).
module sertx_cfg
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic       cmd_tx_en,
    input  logic       cmd_size_hi,
    input  logic       cmd_bit8,
    input  logic       fmt_we,
    input  logic [1:0] fmt_mode,
    input  logic [1:0] fmt_parity,
    input  logic       fmt_stop2,
    input  logic [1:0] fmt_size_lo,
    output frame_cfg_t cfg,
    output logic       bit8_stage,
    output logic       run_ok
);

    logic       en_q;
    logic       size_hi_q;
    logic       bit8_q;
    line_mode_e mode_q;
    logic [1:0] par_q;
    logic       stop2_q;
    logic [1:0] size_lo_q;

    // Command field register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            size_hi_q <= 1'b0;
            bit8_q    <= 1'b0;
        end else if (cmd_we) begin
            en_q      <= cmd_tx_en;
            size_hi_q <= cmd_size_hi;
            bit8_q    <= cmd_bit8;
        end
    end

    // Format field register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_ASYNC;
            par_q     <= 2'b00;
            stop2_q   <= 1'b0;
            size_lo_q <= 2'b11;
        end else if (fmt_we) begin
            mode_q    <= line_mode_e'(fmt_mode);
            par_q     <= fmt_parity;
            stop2_q   <= fmt_stop2;
            size_lo_q <= fmt_size_lo;
        end
    end

    // Decode character size and parity into the frame configuration
    always_comb begin
        unique case ({size_hi_q, size_lo_q})
            3'b000:  cfg.nbits = 4'd5;
            3'b001:  cfg.nbits = 4'd6;
            3'b010:  cfg.nbits = 4'd7;
            3'b111:  cfg.nbits = 4'd9;
            default: cfg.nbits = 4'd8;
        endcase
        cfg.par_en  = par_q[1];
        cfg.par_odd = par_q[1] & par_q[0];
        cfg.stop2   = stop2_q;
    end

    assign bit8_stage = bit8_q;
    assign run_ok     = en_q && (mode_q == MODE_ASYNC);

endmodule

// File: rtl/sertx_hold.sv
// One-entry holding register in front of the shifter.
// Accepts a write only while empty; empties when the shifter takes it.
// Assumes take is only raised while full.
module sertx_hold
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [DATA_MAX-1:0] din,
    input  logic                take,
    output logic                full,
    output logic                accept,
    output logic [DATA_MAX-1:0] dout
);

    assign accept = wr && !full;

    // Capture on accepted write, release when the shifter loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
        end else if (accept) begin
            full <= 1'b1;
            dout <= din;
        end else if (take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/sertx_shift.sv
// Frame shifter: sends a prebuilt frame LSB first, each bit lasting
// TICKS_PER_BIT baud ticks. A load wins over the end of a frame, which
// allows back-to-back frames. The line is high while idle.
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [LEN_W-1:0]   last_idx,
    output logic               line,
    output logic               busy,
    output logic               last_end
);

    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TICKS_PER_BIT - 1);

    logic [FRAME_W-1:0] sh_q;
    logic [LEN_W-1:0]   left_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               bit_end;

    assign bit_end  = busy && tick && (cnt_q == CNT_MAX);
    assign last_end = bit_end && (left_q == '0);

    // Tick counting, bit advance and frame load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            left_q <= '0;
            cnt_q  <= '0;
            busy   <= 1'b0;
        end else if (load) begin
            sh_q   <= frame;
            left_q <= last_idx;
            cnt_q  <= '0;
            busy   <= 1'b1;
        end else if (bit_end) begin
            cnt_q <= '0;
            if (left_q == '0) begin
                busy <= 1'b0;
            end else begin
                sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
                left_q <= left_q - LEN_W'(1);
            end
        end else if (busy && tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign line = busy ? sh_q[0] : 1'b1;

endmodule

// File: rtl/sertx_top.sv
// Buffered asynchronous serial transmitter.
// Claims the pin while enabled in asynchronous mode, and keeps it until the
// buffer and shifter have drained after the enable is withdrawn.
// Assumes baud_tick is a single-cycle pulse from an external rate generator.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       data_we,
    input  logic [7:0] data_in,
    input  logic       cmd_we,
    input  logic       cmd_tx_en,
    input  logic       cmd_size_hi,
    input  logic       cmd_bit8,
    input  logic       fmt_we,
    input  logic [1:0] fmt_mode,
    input  logic [1:0] fmt_parity,
    input  logic       fmt_stop2,
    input  logic [1:0] fmt_size_lo,
    output logic       txd,
    output logic       txd_oe,
    output logic       buf_empty,
    output logic       tx_done
);

    frame_cfg_t          cfg;
    logic                bit8_stage;
    logic                run_ok;
    logic                hold_full;
    logic                hold_accept;
    logic [DATA_MAX-1:0] hold_data;
    logic                sh_busy;
    logic                sh_last_end;
    logic                load;
    logic                own_q;
    logic                done_q;

    sertx_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .cmd_tx_en   (cmd_tx_en),
        .cmd_size_hi (cmd_size_hi),
        .cmd_bit8    (cmd_bit8),
        .fmt_we      (fmt_we),
        .fmt_mode    (fmt_mode),
        .fmt_parity  (fmt_parity),
        .fmt_stop2   (fmt_stop2),
        .fmt_size_lo (fmt_size_lo),
        .cfg         (cfg),
        .bit8_stage  (bit8_stage),
        .run_ok      (run_ok)
    );

    sertx_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (data_we),
        .din    ({bit8_stage, data_in}),
        .take   (load),
        .full   (hold_full),
        .accept (hold_accept),
        .dout   (hold_data)
    );

    // Move a waiting character in when idle or right as the last stop bit ends
    assign load = own_q && hold_full && (!sh_busy || sh_last_end);

    sertx_shift #(
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .load     (load),
        .frame    (frame_build(hold_data, cfg)),
        .last_idx (frame_last(cfg)),
        .line     (txd),
        .busy     (sh_busy),
        .last_end (sh_last_end)
    );

    // Pin ownership: taken on enable, held while anything remains to send
    always_ff @(posedge clk) begin
        if (!rst_n) own_q <= 1'b0;
        else        own_q <= run_ok || (own_q && (hold_full || sh_busy));
    end

    // Transmit-complete flag: set on an unfollowed final stop, cleared by a write
    always_ff @(posedge clk) begin
        if (!rst_n)                         done_q <= 1'b0;
        else if (hold_accept)               done_q <= 1'b0;
        else if (sh_last_end && !hold_full) done_q <= 1'b1;
    end

    assign txd_oe    = own_q;
    assign buf_empty = !hold_full;
    assign tx_done   = done_q;

endmodule

// File: rtl/sertx_chk.sv
// Property checker for the serial transmitter, bound to the top module.
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic data_we,
    input logic txd,
    input logic txd_oe,
    input logic buf_empty,
    input logic tx_done,
    input logic run_ok,
    input logic sh_busy
);

    assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_oe |-> txd);

    assert_start_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> txd_oe);

    assert_claim_async_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txd_oe) |-> $past(run_ok));

    assert_release_drained_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd_oe) |-> (buf_empty && txd && !$past(sh_busy)));

    assert_done_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> (buf_empty && txd));

    assert_write_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_empty && data_we) |=> (!buf_empty && !tx_done));

endmodule

bind sertx_top sertx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_we   (data_we),
    .txd       (txd),
    .txd_oe    (txd_oe),
    .buf_empty (buf_empty),
    .tx_done   (tx_done),
    .run_ok    (run_ok),
    .sh_busy   (sh_busy)
);

// File: tb/sertx_top_tb.sv
// Self-checking bench: a vector table of frame formats, then directed tests.
module sertx_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] data_in = '0;
    logic       cmd_we = 1'b0, cmd_tx_en = 1'b0, cmd_size_hi = 1'b0, cmd_bit8 = 1'b0;
    logic       fmt_we = 1'b0, fmt_stop2 = 1'b0;
    logic [1:0] fmt_mode = '0, fmt_parity = '0, fmt_size_lo = '0;
    logic       txd, txd_oe, buf_empty, tx_done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;
    int tick_div = 1;
    int phase = 0;

    always #5 clk = ~clk;

    sertx_top u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .data_we(data_we), .data_in(data_in),
        .cmd_we(cmd_we), .cmd_tx_en(cmd_tx_en), .cmd_size_hi(cmd_size_hi), .cmd_bit8(cmd_bit8),
        .fmt_we(fmt_we), .fmt_mode(fmt_mode), .fmt_parity(fmt_parity),
        .fmt_stop2(fmt_stop2), .fmt_size_lo(fmt_size_lo),
        .txd(txd), .txd_oe(txd_oe), .buf_empty(buf_empty), .tx_done(tx_done)
    );

    // Baud tick generator: one tick every tick_div clocks
    always @(negedge clk) begin
        phase = (phase + 1) % tick_div;
        baud_tick = (phase == 0);
    end

    // {size code[2:0], parity[1:0], stop2, bit8, data[7:0]}
    localparam logic [14:0] VEC [0:6] = '{
        {3'b011, 2'b00, 1'b0, 1'b0, 8'hA5},
        {3'b000, 2'b10, 1'b0, 1'b0, 8'h13},
        {3'b001, 2'b11, 1'b1, 1'b0, 8'h2C},
        {3'b010, 2'b01, 1'b1, 1'b0, 8'h7F},
        {3'b111, 2'b10, 1'b0, 1'b1, 8'h00},
        {3'b111, 2'b11, 1'b1, 1'b0, 8'hFF},
        {3'b101, 2'b11, 1'b0, 1'b0, 8'h81}
    };

    function automatic int nbits_of(input logic [2:0] code);
        case (code)
            3'b000:  return 5;
            3'b001:  return 6;
            3'b010:  return 7;
            3'b111:  return 9;
            default: return 8;
        endcase
    endfunction

    function automatic logic [15:0] expect_frame(input logic [2:0] code, input logic [1:0] par,
                                                 input logic s2, input logic b8,
                                                 input logic [7:0] d, output int len);
        logic [15:0] f;
        logic [8:0]  dd;
        logic        ones;
        int          n;
        int          pos;
        dd = {b8, d};
        n = nbits_of(code);
        f = '1;
        f[0] = 1'b0;
        ones = 1'b0;
        for (int i = 0; i < n; i++) begin
            f[1+i] = dd[i];
            ones = ones ^ dd[i];
        end
        pos = 1 + n;
        if (par == 2'b10) begin f[pos] = ones; pos++; end
        else if (par == 2'b11) begin f[pos] = ~ones; pos++; end
        len = pos + 1 + int'(s2);
        return f;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic en, input logic hi, input logic b8);
        cmd_we = 1'b1; cmd_tx_en = en; cmd_size_hi = hi; cmd_bit8 = b8;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic fmt(input logic [1:0] mode, input logic [1:0] par, input logic s2,
                       input logic [1:0] lo);
        fmt_we = 1'b1; fmt_mode = mode; fmt_parity = par; fmt_stop2 = s2; fmt_size_lo = lo;
        @(negedge clk);
        fmt_we = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        data_we = 1'b1; data_in = d;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    // Sample every bit at its midpoint; returns at the midpoint of the last bit
    task automatic capture(input string tag, input logic [2:0] code, input logic [1:0] par,
                           input logic s2, input logic b8, input logic [7:0] d,
                           input int per, input bit search, input int skip);
        logic [15:0] exp;
        logic [15:0] got;
        int          len;
        int          sk;
        exp = expect_frame(code, par, s2, b8, d, len);
        got = '1;
        sk = skip;
        if (search) begin
            int w = 0;
            while (txd !== 1'b0 && w < 5000) begin
                @(negedge clk);
                w++;
            end
            if (txd !== 1'b0) begin
                check({tag, " no start bit"}, 32'(txd), 32'd0);
                return;
            end
            sk = 0;
        end
        step(per / 2 - sk);
        got[0] = txd;
        for (int i = 1; i < len; i++) begin
            step(per);
            got[i] = txd;
        end
        check(tag, 32'(got), 32'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(2);

        // R1: reset state
        check("R1 txd", 32'(txd), 32'd1);
        check("R1 txd_oe", 32'(txd_oe), 32'd0);
        check("R1 buf_empty", 32'(buf_empty), 32'd1);
        check("R1 tx_done", 32'(tx_done), 32'd0);

        // R3: synchronous mode code keeps the transmitter off
        fmt(2'b01, 2'b00, 1'b0, 2'b11);
        cmd(1'b1, 1'b0, 1'b0);
        step(2);
        check("R3 no claim", 32'(txd_oe), 32'd0);
        put(8'h5A);
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 40; i++) begin
                if (txd !== 1'b1) quiet = 1'b0;
                step(1);
            end
            check("R3 line quiet", 32'(quiet), 32'd1);
        end
        check("R3 char held", 32'(buf_empty), 32'd0);

        // R2: switching to mode 00 claims the pin one clock later
        fmt(2'b00, 2'b00, 1'b0, 2'b11);
        check("R2 not yet", 32'(txd_oe), 32'd0);
        step(1);
        check("R2 claimed", 32'(txd_oe), 32'd1);
        capture("R2 R4 held frame", 3'b011, 2'b00, 1'b0, 1'b0, 8'h5A, 16, 1'b1, 0);
        step(8);

        // R4 R5 R6 R7 R11: vector table of formats
        for (int v = 0; v < 7; v++) begin
            logic [14:0] e;
            e = VEC[v];
            fmt(2'b00, e[11:10], e[9], e[13:12]);
            cmd(1'b1, e[14], e[8]);
            put(e[7:0]);
            capture("R4 R5 R6 frame", e[14:12], e[11:10], e[9], e[8], e[7:0], 16, 1'b1, 0);
            check("R7 R11 done low in last stop", 32'(tx_done), 32'd0);
            step(8);
            check("R7 R11 done at frame end", 32'(tx_done), 32'd1);
            check("R9 empty after frame", 32'(buf_empty), 32'd1);
        end

        // R9 R10 R11: queued character follows with no gap, write while full dropped
        fmt(2'b00, 2'b00, 1'b0, 2'b11);
        cmd(1'b1, 1'b0, 1'b0);
        put(8'h3C);
        check("R11 write clears done", 32'(tx_done), 32'd0);
        check("R9 write fills", 32'(buf_empty), 32'd0);
        step(1);
        check("R9 empty on load", 32'(buf_empty), 32'd1);
        put(8'hC3);
        put(8'h99);
        check("R9 full holds", 32'(buf_empty), 32'd0);
        capture("R10 first", 3'b011, 2'b00, 1'b0, 1'b0, 8'h3C, 16, 1'b0, 2);
        step(8);
        check("R10 next start at once", 32'(txd), 32'd0);
        check("R11 no done while queued", 32'(tx_done), 32'd0);
        capture("R9 R10 second", 3'b011, 2'b00, 1'b0, 1'b0, 8'hC3, 16, 1'b0, 0);
        step(8);
        check("R11 done after queue", 32'(tx_done), 32'd1);
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 60; i++) begin
                if (txd !== 1'b1) quiet = 1'b0;
                step(1);
            end
            check("R9 dropped write not sent", 32'(quiet), 32'd1);
        end

        // R12: deferred disable
        put(8'h55);
        step(1);
        put(8'hAA);
        cmd(1'b0, 1'b0, 1'b0);
        check("R12 held after disable", 32'(txd_oe), 32'd1);
        capture("R12 first", 3'b011, 2'b00, 1'b0, 1'b0, 8'h55, 16, 1'b0, 2);
        step(8);
        check("R12 queued starts", 32'(txd), 32'd0);
        check("R12 still claimed", 32'(txd_oe), 32'd1);
        capture("R12 second", 3'b011, 2'b00, 1'b0, 1'b0, 8'hAA, 16, 1'b0, 0);
        step(8);
        check("R12 done", 32'(tx_done), 32'd1);
        check("R12 claimed at end", 32'(txd_oe), 32'd1);
        step(1);
        check("R12 released", 32'(txd_oe), 32'd0);
        check("R12 line high", 32'(txd), 32'd1);

        // R8: ninth bit latched with the data write
        fmt(2'b00, 2'b00, 1'b0, 2'b11);
        cmd(1'b1, 1'b1, 1'b1);
        put(8'h0F);
        cmd(1'b1, 1'b1, 1'b0);
        capture("R8 latched one", 3'b111, 2'b00, 1'b0, 1'b1, 8'h0F, 16, 1'b0, 0);
        step(8);
        put(8'h0F);
        capture("R8 latched zero", 3'b111, 2'b00, 1'b0, 1'b0, 8'h0F, 16, 1'b1, 0);
        step(8);

        // R13: bit time follows ticks, not clocks
        cmd(1'b1, 1'b0, 1'b0);
        tick_div = 2;
        step(2);
        put(8'h96);
        capture("R13 half-rate frame", 3'b011, 2'b00, 1'b0, 1'b0, 8'h96, 32, 1'b1, 0);
        step(40);
        check("R13 done", 32'(tx_done), 32'd1);
        tick_div = 1;

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule